// File: doc/BRIEF.md
# Page-Buffered Memory Back End

This block sits behind a two-wire serial slave decoder and supplies the storage side of a small byte-addressed memory. It keeps a byte pointer, a sixteen-slot staging buffer with a valid flag per slot, a 256-cell array held in registers, and a timer that models the internal programming time. The decoder pulses one strobe per event. There is one strobe for a received word address, one for a received data byte, one for a transmitted read byte and one for a Stop that ends a write.

Data bytes are staged in the buffer. Their slot comes from the low pointer bits, and only those low bits advance, so a long write wraps inside its page. On the commit strobe, every valid slot whose enable from the external protect logic is high is copied into the array row of the current page. The block then reports busy for a parameterised number of clock cycles, and it ignores every strobe while busy. Reads present the cell under the pointer combinationally, and each read strobe advances the full pointer.

Top module: `page_store`

## Requirements
- R1: After reset the pointer is 00h, busy is low, no slot is valid and every array cell reads FFh.
- R2: An address strobe loads the pointer from the address input (visible on `cur_addr` one cycle later) and marks every buffer slot invalid.
- R3: A data-byte strobe stores the byte into the slot selected by pointer bits [3:0] and marks it valid. It then increments only bits [3:0], wrapping 1111b to 0000b, while bits [7:4] stay fixed.
- R4: When more than sixteen bytes arrive before a commit, a later byte replaces the earlier one in the same slot, and only the last value per slot is committed.
- R5: The array does not change until a commit strobe. A commit writes slot s to address {pointer[7:4], s}, and cells whose slot was not loaded keep their old contents.
- R6: A slot whose bit s of `slot_allow` is 0 at the commit strobe is not written, even when it is valid.
- R7: A commit with at least one valid slot raises busy in the next cycle for exactly BUSY_CYC cycles. This holds even when every slot is blocked. A commit with no valid slot leaves busy low. Every commit clears all valid flags.
- R8: While busy is high, the address, data, read and commit strobes have no effect on the pointer, the buffer or the array.
- R9: `read_data` always shows the cell addressed by the pointer. A read strobe increments the full 8-bit pointer, wrapping FFh to 00h.
- R10: After a commit the pointer stays one past the last byte staged (within the page), so a current-address read returns that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Word-address strobe |
| addr_in | input | AW (8) | Word address to load |
| byte_load | input | 1 | Received data-byte strobe |
| byte_in | input | DW (8) | Data byte to stage |
| commit | input | 1 | Stop-ends-write strobe |
| slot_allow | input | 2**PW (16) | Per-slot write enable from protect logic |
| read_next | input | 1 | Read byte sent, advance pointer |
| cur_addr | output | AW (8) | Current pointer |
| read_data | output | DW (8) | Cell under the pointer |
| busy | output | 1 | Programming cycle in progress |

## Verification
Every one of the sixteen pages receives a write burst with its own start offset and length. The lengths range from a single byte to a full page and to twenty bytes, so in-page wrap and last-writer-wins are told apart from straight fills. The enable masks include all-on, a checkerboard and all-off, which separates slot gating from buffer validity. The all-off case still has to produce the full busy window. Whole-array sequential reads after reset and a read across FFh confirm that reads carry into the upper pointer bits while writes never do. Strobes sent during busy, and a commit after an address-only sequence, show that the state is held when it should be.

// File: rtl/pgst_pkg.sv
// Shared definitions for the page store: the single operation
// selected per cycle from the incoming strobes.
package pgst_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ADDR   = 3'd1,
        OP_DATA   = 3'd2,
        OP_READ   = 3'd3,
        OP_COMMIT = 3'd4
    } op_e;

    // Priority: commit, address, data, read. Nothing while busy.
    function automatic op_e pick_op(input logic hold, input logic cmt,
                                    input logic adr, input logic dat,
                                    input logic rd);
        if (hold)     return OP_NONE;
        else if (cmt) return OP_COMMIT;
        else if (adr) return OP_ADDR;
        else if (dat) return OP_DATA;
        else if (rd)  return OP_READ;
        else          return OP_NONE;
    endfunction

endpackage

// File: rtl/pgst_ptr.sv
// Byte pointer. Address loads replace it, data bytes advance only
// the in-page bits, reads advance all bits. Assumes at most one op
// per cycle (guaranteed by the package decode).
module pgst_ptr
    import pgst_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [AW-1:0] ld_val,
    output logic [AW-1:0] ptr
);

    // Pointer update per selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                OP_ADDR: ptr <= ld_val;
                OP_DATA: ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                OP_READ: ptr <= ptr + 1'b1;
                default: ptr <= ptr;
            endcase
        end
    end

    // R3
    data_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_DATA |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

    // R3
    data_low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_DATA |=> ptr[PW-1:0] == PW'($past(ptr[PW-1:0]) + 1));

    // R9
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_READ |=> ptr == AW'($past(ptr) + 1));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_ADDR |=> ptr == $past(ld_val));

endmodule

// File: rtl/pgst_buf.sv
// Staging buffer: one byte and one valid flag per in-page slot.
// Flags clear on address load and on commit; assumes the array
// samples slot contents on the same commit edge.
module pgst_buf
    import pgst_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4,
    localparam int PAGE = 1 << PW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_e                      op,
    input  logic [PW-1:0]            slot,
    input  logic [DW-1:0]            din,
    output logic [PAGE-1:0][DW-1:0]  slot_q,
    output logic [PAGE-1:0]          vld
);

    for (genvar s = 0; s < PAGE; s++) begin : g_slot
        // Capture a byte into this slot when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (op == OP_DATA && slot == PW'(s))
                slot_q[s] <= din;
        end

        // Track whether this slot holds a byte for the next commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld[s] <= 1'b0;
            else if (op == OP_ADDR || op == OP_COMMIT)
                vld[s] <= 1'b0;
            else if (op == OP_DATA && slot == PW'(s))
                vld[s] <= 1'b1;
        end
    end

    // R2
    addr_clears_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_ADDR |=> vld == '0);

    // R7
    commit_clears_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_COMMIT |=> vld == '0);

    // R4
    data_marks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_DATA |=> $countones(vld) >= 1);

endmodule

// File: rtl/pgst_array.sv
// Register-modelled cell array. On commit, each valid and enabled
// slot is written into the row of the current page. Read is
// combinational from the pointer.
module pgst_array
    import pgst_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int PW = 4,
    localparam int DEPTH = 1 << AW,
    localparam int PAGE  = 1 << PW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_e                      op,
    input  logic [AW-PW-1:0]         page,
    input  logic [PAGE-1:0][DW-1:0]  slot_q,
    input  logic [PAGE-1:0]          vld,
    input  logic [PAGE-1:0]          allow,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Erase on reset, commit gated slots into the current page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (op == OP_COMMIT) begin
            for (int s = 0; s < PAGE; s++) begin
                if (vld[s] && allow[s])
                    mem[{page, PW'(s)}] <= slot_q[s];
            end
        end
    end

    // Present the addressed cell
    assign rd_data = mem[rd_addr];

    // R5
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op != OP_COMMIT |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

endmodule

// File: rtl/pgst_timer.sv
// Programming-time model: counts CYC cycles after a start pulse.
// Assumes CYC >= 1 and no start while busy (decode gates it).
module pgst_timer #(
    parameter int CYC = 500000,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] cnt;

    // Load on start, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CYC));

endmodule

// File: rtl/page_store.sv
// Memory back end for a serial slave: pointer, staging buffer,
// cell array and programming timer. Assumes the decoder pulses each
// strobe for one cycle; strobes are dropped while busy is high.
module page_store
    import pgst_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int PW       = 4,
    parameter int BUSY_CYC = 500000,
    localparam int PAGE    = 1 << PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_load,
    input  logic [AW-1:0]   addr_in,
    input  logic            byte_load,
    input  logic [DW-1:0]   byte_in,
    input  logic            commit,
    input  logic [PAGE-1:0] slot_allow,
    input  logic            read_next,
    output logic [AW-1:0]   cur_addr,
    output logic [DW-1:0]   read_data,
    output logic            busy
);

    op_e                    op;
    logic [PAGE-1:0][DW-1:0] slot_q;
    logic [PAGE-1:0]        vld;
    logic                   start;

    // Select this cycle's operation
    always_comb op = pick_op(busy, commit, addr_load, byte_load, read_next);

    // A programming cycle only follows a commit that has staged data
    assign start = (op == OP_COMMIT) && (|vld);

    pgst_ptr #(.AW(AW), .PW(PW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(op), .ld_val(addr_in), .ptr(cur_addr)
    );

    pgst_buf #(.DW(DW), .PW(PW)) u_buf (
        .clk(clk), .rst_n(rst_n), .op(op), .slot(cur_addr[PW-1:0]),
        .din(byte_in), .slot_q(slot_q), .vld(vld)
    );

    pgst_array #(.AW(AW), .DW(DW), .PW(PW)) u_arr (
        .clk(clk), .rst_n(rst_n), .op(op), .page(cur_addr[AW-1:PW]),
        .slot_q(slot_q), .vld(vld), .allow(slot_allow),
        .rd_addr(cur_addr), .rd_data(read_data)
    );

    pgst_timer #(.CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    // R8
    busy_freezes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));

    // R8
    busy_freezes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(read_data));

endmodule

// File: tb/tb_page_store.sv
module tb_page_store;

    localparam int BUSY = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [7:0]  addr_in = '0;
    logic        byte_load = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        commit = 1'b0;
    logic [15:0] slot_allow = '0;
    logic        read_next = 1'b0;
    logic [7:0]  cur_addr;
    logic [7:0]  read_data;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [256];
    logic [7:0] m_buf [16];
    logic [15:0] m_vld;
    logic [7:0] m_ptr;

    always #5 clk = ~clk;

    page_store #(.BUSY_CYC(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in), .commit(commit),
        .slot_allow(slot_allow), .read_next(read_next),
        .cur_addr(cur_addr), .read_data(read_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_addr(input logic [7:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        m_ptr = a; m_vld = '0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        byte_load = 1'b1; byte_in = d;
        @(negedge clk);
        byte_load = 1'b0;
        m_buf[m_ptr[3:0]] = d;
        m_vld[m_ptr[3:0]] = 1'b1;
        m_ptr[3:0] = m_ptr[3:0] + 4'd1;
    endtask

    task automatic do_read();
        read_next = 1'b1;
        @(negedge clk);
        read_next = 1'b0;
        m_ptr = m_ptr + 8'd1;
    endtask

    // Commit, apply the model, then measure the busy window (R7)
    task automatic do_commit(input logic [15:0] mask, input string req);
        int exp_len;
        int cnt;
        exp_len = (m_vld != '0) ? BUSY : 0;
        commit = 1'b1; slot_allow = mask;
        @(negedge clk);
        commit = 1'b0;
        for (int s = 0; s < 16; s++)
            if (m_vld[s] && mask[s]) m_mem[{m_ptr[7:4], 4'(s)}] = m_buf[s];
        m_vld = '0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp_len, req, cnt, exp_len);
    endtask

    task automatic check_page(input int p, input string req);
        do_addr(8'(p * 16));
        for (int i = 0; i < 16; i++) begin
            chk(read_data == m_mem[m_ptr], req, read_data, m_mem[m_ptr]);
            do_read();
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
        m_vld = '0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and erased array, read across the whole space (R9)
        chk(cur_addr == 8'h00, "R1 ptr", cur_addr, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        for (int i = 0; i < 256; i++) begin
            chk(read_data == 8'hFF, "R1 cell", read_data, 8'hFF);
            do_read();
        end
        // R9: full pointer wrapped FFh to 00h
        chk(cur_addr == 8'h00, "R9 wrap", cur_addr, 0);

        // R3 R4 R5 R6 R7 R10: a burst per page
        for (int p = 0; p < 16; p++) begin
            int n;
            logic [15:0] mask;
            string tag;
            n = (p == 3) ? 20 : (p == 5) ? 16 : (p % 7) + 1;
            mask = (p == 6) ? 16'h0000 : (p % 4 == 1) ? 16'hA5A5 : 16'hFFFF;
            tag = (p == 3) ? "R4 overflow" : (p == 6) ? "R6 blocked" :
                  (p % 4 == 1) ? "R6 mask" : "R5 commit";
            do_addr(8'(p * 16 + (p * 5) % 16));
            chk(cur_addr == m_ptr, "R2 load", cur_addr, m_ptr);
            for (int i = 0; i < n; i++) do_byte(8'(p * 37 + i * 11 + 5));
            chk(cur_addr == m_ptr, "R3 in-page step", cur_addr, m_ptr);
            chk(read_data == m_mem[m_ptr], "R5 before commit", read_data, m_mem[m_ptr]);
            do_commit(mask, "R7 busy length");
            chk(cur_addr == m_ptr, "R10 ptr kept", cur_addr, m_ptr);
            chk(read_data == m_mem[m_ptr], "R10 current read", read_data, m_mem[m_ptr]);
            check_page(p, tag);
        end

        // R8: strobes during busy are dropped
        do_addr(8'h47);
        do_byte(8'h5A);
        commit = 1'b1; slot_allow = 16'hFFFF;
        @(negedge clk);
        commit = 1'b0;
        m_mem[8'h47] = 8'h5A; m_vld = '0;
        chk(busy == 1'b1, "R7 busy rise", busy, 1);
        addr_load = 1'b1; addr_in = 8'h33; byte_load = 1'b1; byte_in = 8'hC3;
        @(negedge clk);
        addr_load = 1'b0; byte_load = 1'b0;
        read_next = 1'b1;
        @(negedge clk);
        read_next = 1'b0;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        while (busy) @(negedge clk);
        chk(cur_addr == m_ptr, "R8 ptr held", cur_addr, m_ptr);
        chk(read_data == m_mem[m_ptr], "R8 data held", read_data, m_mem[m_ptr]);
        do_commit(16'hFFFF, "R8 byte dropped");
        check_page(4, "R8 array held");

        // R2: address load discards staged bytes
        do_addr(8'h20);
        do_byte(8'h99);
        do_addr(8'h80);
        do_commit(16'hFFFF, "R2 valid cleared");
        check_page(2, "R2 array untouched");

        // R9: read carries into upper bits
        do_addr(8'h0F);
        do_read();
        chk(cur_addr == 8'h10, "R9 carry", cur_addr, 8'h10);
        chk(read_data == m_mem[8'h10], "R9 data", read_data, m_mem[8'h10]);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule